// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request port and an external asynchronous static RAM with 32,768 bytes. The internal side offers a valid/ready handshake that carries a read/write flag, a 15-bit address and a byte of write data. Read results come back as a byte with a one-cycle valid strobe. The memory side drives the active-low select, output-enable and write-enable lines and the address bus. It also drives a split data bus: output data, a driver enable and the returned input data. A board-level tri-state buffer merges these onto the shared pins.

Every memory timing figure is a parameter in nanoseconds. The controller converts each one to whole clock cycles, rounding up. A read keeps select and output enable low long enough for the access time to pass, then samples the bus. A write keeps output enable high, drives the data bus, and holds write enable low for the pulse width. Data stays settled for the setup time before write enable rises. After any read the controller waits out the memory's output turn-off time before it may drive the bus again. Select returns high between operations, which puts the memory in standby.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset, and whenever the controller is idle, sramCsN, sramOeN and sramWeN are all 1, sramDqOe is 0, rdValid is 0 and reqReady is 1.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both 1. reqReady stays 0 from the cycle after acceptance until the operation has finished. The address and write data are captured at acceptance, and sramAddr stays constant while sramCsN is 0, whatever the request inputs do in that time.
- R3: A read holds sramCsN=0, sramOeN=0 and sramWeN=1 for RD_CYC cycles, where RD_CYC = max(ceil(T_RC_NS/CLK_NS), ceil(T_AA_NS/CLK_NS)). This is 6 cycles at the defaults. The bus is sampled on the clock edge that ends the last of those cycles.
- R4: rdValid is 1 for exactly one cycle after the read access, and rdData then holds the sampled byte.
- R5: During a write, sramOeN stays 1 throughout. sramWeN stays 0 with sramCsN=0 for WE_CYC cycles, where WE_CYC = max(ceil(T_PWE_NS/CLK_NS), ceil(T_AW_NS/CLK_NS)). This is 4 cycles at the defaults.
- R6: For a write, sramDqOe is 1 and sramDqOut is constant for at least ceil(T_SD_NS/CLK_NS) cycles up to the rise of sramWeN (3 at the defaults), and through the cycle in which sramWeN has risen.
- R7: sramDqOe is never 1 while sramOeN is 0. At least 2 cycles with sramOeN=1 lie between the end of a read and the first cycle with sramDqOe=1.
- R8: sramCsN is 1 in the cycle in which a new request is accepted, so select goes high between any two operations.
- R9: A read of any address, including 15'h0000 and 15'h7FFF, returns the byte most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Byte address |
| reqWdata | input | 8 | Write data |
| rdValid | output | 1 | One-cycle read-data strobe |
| rdData | output | 8 | Read data |
| sramAddr | output | 15 | Memory address bus |
| sramCsN | output | 1 | Memory select, active low |
| sramOeN | output | 1 | Memory output enable, active low |
| sramWeN | output | 1 | Memory write enable, active low |
| sramDqOut | output | 8 | Data driven toward the memory |
| sramDqOe | output | 1 | Enable for the controller's data drivers |
| sramDqIn | input | 8 | Data returned from the memory bus |

## Verification
The bench's memory model returns a garbage byte until the address and select have been stable for the full access time. A read that samples even one cycle early therefore returns a wrong byte instead of silently passing. Writes are committed to the model only when select and write enable stop overlapping. A pulse that is too short is flagged, and so is data that changes too close to the end of the pulse or drops at the terminating edge. These faults would corrupt a real part without the error showing in the data. Read-then-write pairs target bus turnaround: a controller that enabled its drivers too soon would be caught fighting the memory on the bus. Scrambled request inputs during busy cycles expose a controller that fails to latch its request.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic selN;      // memory select level
    logic outEnN;    // memory output enable level
    logic wrEnN;     // memory write enable level
    logic busDrive;  // enable our data drivers
    logic loadReq;   // capture request address and data
    logic grabData;  // sample the bus into the read register
  } asramStrobe_t;

  function automatic int nsToCycles(int ns, int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 6,
  parameter int SU_CYC = 1,
  parameter int WE_CYC = 4,
  parameter int HD_CYC = 1,
  parameter int TA_CYC = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output asramStrobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WE_CYC),
                                 maxOf(maxOf(SU_CYC, HD_CYC), TA_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } phase_t;

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] stepCnt, stepLimit;
  logic             stepDone, accept;

  always_comb begin
    case (phase)
      PH_READ:  stepLimit = CNT_W'(RD_CYC - 1);
      PH_TURN:  stepLimit = CNT_W'(TA_CYC - 1);
      PH_SETUP: stepLimit = CNT_W'(SU_CYC - 1);
      PH_PULSE: stepLimit = CNT_W'(WE_CYC - 1);
      PH_HOLD:  stepLimit = CNT_W'(HD_CYC - 1);
      default:  stepLimit = '0;
    endcase
  end

  assign stepDone = (stepCnt == stepLimit);
  assign accept   = (phase == PH_IDLE) && reqValid;
  assign reqReady = (phase == PH_IDLE);

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:  if (accept) phaseNext = reqWrite ? PH_SETUP : PH_READ;
      PH_READ:  if (stepDone) phaseNext = PH_TURN;
      PH_TURN:  if (stepDone) phaseNext = PH_IDLE;
      PH_SETUP: if (stepDone) phaseNext = PH_PULSE;
      PH_PULSE: if (stepDone) phaseNext = PH_HOLD;
      PH_HOLD:  if (stepDone) phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      stepCnt <= '0;
    end else begin
      phase <= phaseNext;
      if (phaseNext != phase || phase == PH_IDLE) stepCnt <= '0;
      else                                        stepCnt <= stepCnt + 1'b1;
    end
  end

  // Strobe decode from the registered phase: one level of logic per pin.
  always_comb begin
    strobe = '{selN: 1'b1, outEnN: 1'b1, wrEnN: 1'b1,
               busDrive: 1'b0, loadReq: 1'b0, grabData: 1'b0};
    case (phase)
      PH_IDLE:  strobe.loadReq = accept;
      PH_READ: begin
        strobe.selN     = 1'b0;
        strobe.outEnN   = 1'b0;
        strobe.grabData = stepDone;
      end
      PH_SETUP, PH_HOLD: begin
        strobe.selN     = 1'b0;
        strobe.busDrive = 1'b1;
      end
      PH_PULSE: begin
        strobe.selN     = 1'b0;
        strobe.wrEnN    = 1'b0;
        strobe.busDrive = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  asramStrobe_t      strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rdQ;
  logic              validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      rdQ    <= '0;
      validQ <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
      end
      if (strobe.grabData) rdQ <= sramDqIn;
      validQ <= strobe.grabData;
    end
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = dataQ;
  assign sramDqOe  = strobe.busDrive;
  assign sramCsN   = strobe.selN;
  assign sramOeN   = strobe.outEnN;
  assign sramWeN   = strobe.wrEnN;
  assign rdData    = rdQ;
  assign rdValid   = validQ;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 8,
  parameter int T_RC_NS  = 45,
  parameter int T_AA_NS  = 45,
  parameter int T_PWE_NS = 25,
  parameter int T_AW_NS  = 25,
  parameter int T_SD_NS  = 20,
  parameter int T_WC_NS  = 45,
  parameter int T_HZ_NS  = 20,
  parameter int TURN_MIN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int RD_CYC = maxOf(nsToCycles(T_RC_NS, CLK_NS), nsToCycles(T_AA_NS, CLK_NS));
  localparam int WE_CYC = maxOf(nsToCycles(T_PWE_NS, CLK_NS), nsToCycles(T_AW_NS, CLK_NS));
  localparam int SU_CYC = maxOf(1, nsToCycles(T_SD_NS, CLK_NS) - WE_CYC);
  localparam int HD_CYC = maxOf(1, nsToCycles(T_WC_NS, CLK_NS) - WE_CYC - SU_CYC);
  localparam int TA_CYC = maxOf(TURN_MIN, nsToCycles(T_HZ_NS, CLK_NS));

  asramStrobe_t strobe;

  asram_seq #(
    .RD_CYC(RD_CYC), .SU_CYC(SU_CYC), .WE_CYC(WE_CYC),
    .HD_CYC(HD_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe)
  );

  asram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .rdValid(rdValid),
    .sramAddr(sramAddr), .sramCsN(sramCsN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int TURN_MIN = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCsN,
  input logic              sramOeN,
  input logic              sramWeN,
  input logic [DATA_W-1:0] sramDqOut,
  input logic              sramDqOe
);

  // Count of completed output-enable-high cycles, saturating.
  logic [2:0] oeHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 oeHighCnt <= 3'd7;
    else if (!sramOeN)         oeHighCnt <= 3'd0;
    else if (oeHighCnt != 3'd7) oeHighCnt <= oeHighCnt + 3'd1;
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCsN && sramOeN && sramWeN && !sramDqOe));

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCsN && !$past(sramCsN)) |-> $stable(sramAddr));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_oe_high_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (sramOeN && !sramCsN));

  assert_data_during_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramDqOe);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (sramDqOe && $stable(sramDqOut)));

  assert_no_fight_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> !sramDqOe);

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> (oeHighCnt >= 3'(TURN_MIN)));

endmodule

bind asram_ctrl asram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN_MIN(TURN_MIN)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .sramAddr(sramAddr), .sramCsN(sramCsN), .sramOeN(sramOeN), .sramWeN(sramWeN),
  .sramDqOut(sramDqOut), .sramDqOe(sramDqOe)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

  localparam int CLK_NS = 8;
  localparam int RD_CYC = (45 + CLK_NS - 1) / CLK_NS;  // 6
  localparam int WE_CYC = (25 + CLK_NS - 1) / CLK_NS;  // 4
  localparam int DS_CYC = (20 + CLK_NS - 1) / CLK_NS;  // 3

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rdValid;
  logic [7:0]  rdData;
  logic [14:0] sramAddr;
  logic        sramCsN, sramOeN, sramWeN, sramDqOe;
  logic [7:0]  sramDqOut, sramDqIn;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  asram_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .sramAddr(sramAddr),
    .sramCsN(sramCsN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  // ---------------- memory model ----------------
  logic [7:0] modelMem [int unsigned];
  logic [7:0] shadowMem [int unsigned];
  int         rdCnt;
  logic [14:0] rdAddrQ;
  logic        rdActQ;
  logic        memDrive;
  logic [7:0]  memByte;

  function automatic logic [7:0] modelRead(logic [14:0] a);
    if (modelMem.exists(int'(a))) return modelMem[int'(a)];
    return 8'h00;
  endfunction

  function automatic logic [7:0] expRead(logic [14:0] a);
    if (shadowMem.exists(int'(a))) return shadowMem[int'(a)];
    return 8'h00;
  endfunction

  assign memDrive = !sramCsN && !sramOeN && sramWeN;
  always_comb memByte = (rdCnt >= RD_CYC - 1) ? modelRead(sramAddr) : 8'hEE;
  assign sramDqIn = memDrive ? memByte : (sramDqOe ? sramDqOut : 8'h5A);

  always @(posedge clk) begin
    if (memDrive) rdCnt <= (rdActQ && rdAddrQ == sramAddr) ? rdCnt + 1 : 1;
    else          rdCnt <= 0;
    rdActQ  <= memDrive;
    rdAddrQ <= sramAddr;
  end

  function automatic void report(string req, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endfunction

  // Write monitor: commits at the edge that ends the select/write overlap.
  bit         wrPrev = 0, csPrevLow = 0;
  int         weLow = 0, stableCnt = 0, wrStable = 0;
  logic [14:0] wrAddr = '0, csAddr = '0;
  logic [7:0]  wrData = '0, lastOut = '0;
  always @(posedge clk) begin
    bit wrNow;
    if (rstN) begin
      if (!sramCsN && csPrevLow && sramAddr != csAddr)
        report("R2", "address moved while selected", sramAddr, csAddr);
      csPrevLow = !sramCsN; csAddr = sramAddr;
      if (sramDqOe) stableCnt = (stableCnt > 0 && sramDqOut == lastOut) ? stableCnt + 1 : 1;
      else          stableCnt = 0;
      lastOut = sramDqOut;
      wrNow = !sramCsN && !sramWeN;
      if (wrNow) begin
        if (!wrPrev) begin weLow = 0; wrAddr = sramAddr; end
        weLow++;
        wrData = sramDqOut;
        wrStable = stableCnt;
        if (!sramOeN) report("R5", "oe low during write", 0, 1);
        if (!sramDqOe) report("R6", "drivers off during pulse", 0, 1);
      end else if (wrPrev) begin
        checks++;
        if (weLow < WE_CYC) report("R5", "write pulse cycles", weLow, WE_CYC);
        if (wrStable < DS_CYC) report("R6", "data setup cycles", wrStable, DS_CYC);
        if (!sramDqOe || sramDqOut != wrData) report("R6", "data hold", sramDqOut, wrData);
        modelMem[int'(wrAddr)] = wrData;
      end
      wrPrev = wrNow;
    end
  end

  // Read-phase length, turnaround and contention monitor.
  int oeLowRun = 0, oeHighRun = 8;
  always @(negedge clk) begin
    if (rstN) begin
      if (!sramOeN) begin oeLowRun++; oeHighRun = 0; end
      else begin
        if (oeLowRun > 0) begin
          checks++;
          if (oeLowRun < RD_CYC) report("R3", "read access cycles", oeLowRun, RD_CYC);
          if (oeLowRun > 0 && sramWeN == 1'b0) report("R3", "we low in read", 0, 1);
        end
        oeLowRun = 0;
        if (oeHighRun < 100) oeHighRun++;
      end
      if (sramDqOe && memDrive) report("R7", "bus contention", 1, 0);
      if (sramDqOe && oeHighRun < 3) report("R7", "turnaround cycles", oeHighRun - 1, 2);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(bit wr, logic [14:0] a, logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    checks++;
    if (sramCsN !== 1'b1) report("R8", "select low at acceptance", sramCsN, 1);
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'($urandom); reqAddr = 15'($urandom); reqWdata = 8'($urandom);
    checks++;
    if (reqReady !== 1'b0) report("R2", "ready after acceptance", reqReady, 0);
  endtask

  task automatic doWrite(logic [14:0] a, logic [7:0] d);
    issue(1'b1, a, d);
    shadowMem[int'(a)] = d;
  endtask

  task automatic doRead(logic [14:0] a);
    int n = 0;
    logic [7:0] exp = expRead(a);
    issue(1'b0, a, 8'h00);
    while (!rdValid && n < 40) begin @(negedge clk); n++; end
    checks++;
    if (!rdValid) report("R4", "no read strobe", 0, 1);
    else if (rdData !== exp) report("R9", "read data", rdData, exp);
    @(negedge clk);
    checks++;
    if (rdValid !== 1'b0) report("R4", "strobe longer than one cycle", rdValid, 0);
    if (rdData !== exp) report("R4", "read data not held", rdData, exp);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    checks++;
    if ({sramCsN, sramOeN, sramWeN, sramDqOe, reqReady, rdValid} !== 6'b111010)
      report("R1", "reset pin state",
             {sramCsN, sramOeN, sramWeN, sramDqOe, reqReady, rdValid}, 6'b111010);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if ({sramCsN, sramOeN, sramWeN, sramDqOe, reqReady, rdValid} !== 6'b111010)
      report("R1", "idle pin state",
             {sramCsN, sramOeN, sramWeN, sramDqOe, reqReady, rdValid}, 6'b111010);

    // Directed: boundary addresses, read-then-write turnaround, unwritten read.
    doWrite(15'h0000, 8'hA5);
    doWrite(15'h7FFF, 8'h5A);
    doRead(15'h0000);
    doRead(15'h7FFF);
    doRead(15'h1234);
    doWrite(15'h1234, 8'hC3);
    doRead(15'h1234);
    doWrite(15'h1234, 8'h3C);
    doWrite(15'h0001, 8'hFF);
    doRead(15'h1234);
    doRead(15'h0001);

    // Random mix over a small pool so reads hit earlier writes.
    for (int i = 0; i < 150; i++) begin
      int sel = int'($urandom % 8);
      logic [14:0] a;
      if (sel == 0)      a = 15'h0000;
      else if (sel == 1) a = 15'h7FFF;
      else if (sel < 6)  a = 15'($urandom % 16);
      else               a = 15'($urandom);
      if ($urandom % 2) doWrite(a, 8'($urandom));
      else              doRead(a);
    end

    while (!reqReady) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if ({sramCsN, sramOeN, sramWeN, sramDqOe} !== 4'b1110)
      report("R1", "final idle pins", {sramCsN, sramOeN, sramWeN, sramDqOe}, 4'b1110);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule